// File: doc/BRIEF.md
# Bus Start/Stop Condition Detector

This block watches the two wires of an I2C bus, clock line and data line, and reports the framing events that a slave byte engine needs. It brings both raw pin levels into the system clock domain through a synchronizer chain. It then compares each synchronized sample with the one before it. A falling data line while the clock line stays high is reported as a start. A rising data line while the clock line stays high is reported as a stop. Each event appears as a single-cycle pulse. A stop pulse doubles as the clear signal for the slave's receive logic. A start pulse tells the byte engine to begin address reception again, including when no stop came before it.

Two sticky flags record which kind of event came last. They exclude each other, and both read zero after reset until the bus shows its first event. A bus-idle output is high whenever no start has been seen since the last stop or reset. An optional mode, selected by a level input, also drives an event pulse on every start and stop. Firmware can use that pulse as an interrupt to track when the bus goes idle.

Top module: `bus_cond_detect`

## Requirements
- R1: A fall of the data line while the clock line is high gives `start_pulse` high for exactly one system clock cycle.
- R2: A rise of the data line while the clock line is high gives `rx_clear` high for exactly one system clock cycle.
- R3: `seen_start` is set by a start and cleared by a stop. `seen_stop` is set by a stop and cleared by a start. The two are never high together and hold their value between events.
- R4: After reset, and during reset, `seen_start`, `seen_stop`, `start_pulse`, `rx_clear`, `rep_start` and `evt_irq` are 0 and `bus_idle` is 1.
- R5: A data line change is reported only if the clock line was high in both the previous and the current synchronized sample. Data changes while the clock is low, and data changes in the same sample as a clock transition, produce no event.
- R6: `rep_start` pulses for one cycle, one cycle after `start_pulse`, when that start arrived while `seen_start` was already 1 (a start with no stop before it).
- R7: When `irq_en` is 1, every start and every stop gives one single-cycle `evt_irq` pulse, one cycle after the event pulse. When `irq_en` is 0, `evt_irq` stays 0.
- R8: `bus_idle` is 1 exactly when `seen_start` is 0.
- R9: With SYNC_STAGES synchronizer flops, the event pulse rises at the (SYNC_STAGES+1)-th rising clock edge after the data line change. The flags, `rep_start` and `evt_irq` follow one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| irq_en | input | 1 | 1 enables the event pulse on start and stop |
| start_pulse | output | 1 | One-cycle pulse on start or repeated start |
| rx_clear | output | 1 | One-cycle pulse on stop, clears slave receive logic |
| rep_start | output | 1 | One-cycle pulse marking a start that had no stop before it |
| seen_start | output | 1 | Sticky: last bus event was a start |
| seen_stop | output | 1 | Sticky: last bus event was a stop |
| bus_idle | output | 1 | No start since the last stop or reset |
| evt_irq | output | 1 | One-cycle event pulse in the optional mode |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. This places the event pulse three edges after a data change and the flags four edges after it, and the latency test checks exactly those cycles. With only two stages, simultaneous changes of both lines and edges that coincide with a clock transition can be produced directly from the bench. The vector walk uses them to show that such changes are rejected. It also covers a repeated start, and the interrupt mode both switched on and switched off.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_STOP  = 2'd2
  } bus_ev_e;

  // Level a released open-drain line rests at.
  localparam logic LINE_REST = 1'b1;
endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_raw,
  output logic [WIDTH-1:0] q_sync
);
  import bcd_pkg::*;
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= {WIDTH{LINE_REST}};
        else        stg[0] <= d_raw;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= {WIDTH{LINE_REST}};
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q_sync = stg[LAST];
endmodule

// File: rtl/cond_classify.sv
module cond_classify (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o
);
  import bcd_pkg::*;

  logic    scl_p, sda_p;
  bus_ev_e ev_nxt, ev_q;

  always_comb begin
    ev_nxt = EV_NONE;
    if (scl_p && scl_s) begin
      if (sda_p && !sda_s)      ev_nxt = EV_START;
      else if (!sda_p && sda_s) ev_nxt = EV_STOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= LINE_REST;
      sda_p <= LINE_REST;
      ev_q  <= EV_NONE;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      ev_q  <= ev_nxt;
    end
  end

  assign start_o = (ev_q == EV_START);
  assign stop_o  = (ev_q == EV_STOP);

  // R1
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R2
  stop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
  // R5
  start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(scl_s));
endmodule

// File: rtl/cond_status.sv
module cond_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic irq_en_i,
  output logic seen_start_o,
  output logic seen_stop_o,
  output logic rep_start_o,
  output logic irq_o
);
  logic ss_q, sp_q, rep_q, irq_q;
  logic ss_n, sp_n, rep_n, irq_n;

  always_comb begin
    ss_n  = ss_q;
    sp_n  = sp_q;
    if (start_i) begin
      ss_n = 1'b1;
      sp_n = 1'b0;
    end else if (stop_i) begin
      ss_n = 1'b0;
      sp_n = 1'b1;
    end
    rep_n = start_i && ss_q;
    irq_n = irq_en_i && (start_i || stop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q  <= 1'b0;
      sp_q  <= 1'b0;
      rep_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ss_q  <= ss_n;
      sp_q  <= sp_n;
      rep_q <= rep_n;
      irq_q <= irq_n;
    end
  end

  assign seen_start_o = ss_q;
  assign seen_stop_o  = sp_q;
  assign rep_start_o  = rep_q;
  assign irq_o        = irq_q;

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_q && sp_q));
  // R3
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ss_q && !sp_q));
  // R3
  stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (sp_q && !ss_q));
  // R6
  rep_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> $past(start_i));
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |=> !irq_q);
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic irq_en,
  output logic start_pulse,
  output logic rx_clear,
  output logic rep_start,
  output logic seen_start,
  output logic seen_stop,
  output logic bus_idle,
  output logic evt_irq
);
  localparam int LINES = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic [LINES-1:0] lines_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  cond_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sn),
    .d_raw  ({scl_in, sda_in}),
    .q_sync (lines_s)
  );

  cond_classify u_class (
    .clk     (clk),
    .rst_n   (rst_sn),
    .scl_s   (lines_s[1]),
    .sda_s   (lines_s[0]),
    .start_o (start_pulse),
    .stop_o  (rx_clear)
  );

  cond_status u_stat (
    .clk          (clk),
    .rst_n        (rst_sn),
    .start_i      (start_pulse),
    .stop_i       (rx_clear),
    .irq_en_i     (irq_en),
    .seen_start_o (seen_start),
    .seen_stop_o  (seen_stop),
    .rep_start_o  (rep_start),
    .irq_o        (evt_irq)
  );

  assign bus_idle = !seen_start;

  // R1
  no_dual_event_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(start_pulse && rx_clear));
  // R7
  irq_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_irq |-> $past(start_pulse || rx_clear));
endmodule

// File: tb/test_bus_cond_detect.sv
module test_bus_cond_detect;
  logic clk = 1'b0;
  logic rst_n, scl, sda, ien;
  logic start_pulse, rx_clear, rep_start, seen_start, seen_stop, bus_idle, evt_irq;

  int checks = 0, errors = 0, cyc = 0;
  int n_st = 0, n_sp = 0, n_rs = 0, n_ir = 0, dbl = 0;
  logic prev_st = 1'b0, prev_sp = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cond_detect i_bus_cond_detect (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .irq_en(ien),
    .start_pulse(start_pulse), .rx_clear(rx_clear), .rep_start(rep_start),
    .seen_start(seen_start), .seen_stop(seen_stop), .bus_idle(bus_idle),
    .evt_irq(evt_irq)
  );

  typedef struct packed {
    logic       scl, sda, ien;
    logic [3:0] st, sp, rs, ir;
    logic       ss, ps, idle;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1,1,0, 0,0,0,0, 0,0,1},
    '{1,0,0, 1,0,0,0, 1,0,0},
    '{0,0,0, 1,0,0,0, 1,0,0},
    '{0,1,0, 1,0,0,0, 1,0,0},
    '{1,1,0, 1,0,0,0, 1,0,0},
    '{0,1,0, 1,0,0,0, 1,0,0},
    '{0,0,0, 1,0,0,0, 1,0,0},
    '{1,0,0, 1,0,0,0, 1,0,0},
    '{1,1,0, 1,1,0,0, 0,1,1},
    '{1,0,0, 2,1,0,0, 1,0,0},
    '{0,0,0, 2,1,0,0, 1,0,0},
    '{0,1,0, 2,1,0,0, 1,0,0},
    '{1,1,0, 2,1,0,0, 1,0,0},
    '{1,0,0, 3,1,1,0, 1,0,0},
    '{1,1,1, 3,2,1,1, 0,1,1},
    '{1,0,1, 4,2,1,2, 1,0,0},
    '{0,0,1, 4,2,1,2, 1,0,0},
    '{0,1,1, 4,2,1,2, 1,0,0},
    '{1,0,1, 4,2,1,2, 1,0,0},
    '{0,0,1, 4,2,1,2, 1,0,0},
    '{1,1,1, 4,2,1,2, 1,0,0},
    '{1,0,1, 5,2,2,3, 1,0,0},
    '{1,1,0, 5,3,2,3, 0,1,1}
  };

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      n_st += int'(start_pulse);
      n_sp += int'(rx_clear);
      n_rs += int'(rep_start);
      n_ir += int'(evt_irq);
      if ((start_pulse && prev_st) || (rx_clear && prev_sp)) dbl++;
    end
    prev_st <= start_pulse;
    prev_sp <= rx_clear;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!done && cyc > 5000) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; ien = 1'b0;
    wait_neg(3);
    // R4 during reset
    chk("R4", "seen_start in reset", int'(seen_start), 0);
    chk("R4", "bus_idle in reset", int'(bus_idle), 1);
    rst_n = 1'b1;
    wait_neg(6);
    // R4 after reset
    chk("R4", "seen_start", int'(seen_start), 0);
    chk("R4", "seen_stop", int'(seen_stop), 0);
    chk("R4", "pulses", int'(start_pulse) + int'(rx_clear) + int'(rep_start) + int'(evt_irq), 0);
    chk("R8", "bus_idle after reset", int'(bus_idle), 1);

    // vector walk: R1 R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      scl = VEC[i].scl; sda = VEC[i].sda; ien = VEC[i].ien;
      wait_neg(6);
      chk("R1", $sformatf("start count v%0d", i), n_st, int'(VEC[i].st));
      chk("R2", $sformatf("stop count v%0d", i), n_sp, int'(VEC[i].sp));
      chk("R6", $sformatf("repeat count v%0d", i), n_rs, int'(VEC[i].rs));
      chk("R7", $sformatf("irq count v%0d", i), n_ir, int'(VEC[i].ir));
      chk("R3", $sformatf("seen_start v%0d", i), int'(seen_start), int'(VEC[i].ss));
      chk("R3", $sformatf("seen_stop v%0d", i), int'(seen_stop), int'(VEC[i].ps));
      chk("R8", $sformatf("bus_idle v%0d", i), int'(bus_idle), int'(VEC[i].idle));
    end
    // R1 R2 single-cycle width
    chk("R1", "multi-cycle pulses", dbl, 0);

    // R9 latency: bus rests at scl=1 sda=1, seen_stop=1
    ien = 1'b1;
    sda = 1'b0;
    @(negedge clk); chk("R9", "start after edge 1", int'(start_pulse), 0);
    @(negedge clk); chk("R9", "start after edge 2", int'(start_pulse), 0);
    @(negedge clk); chk("R9", "start after edge 3", int'(start_pulse), 1);
    chk("R9", "seen_start after edge 3", int'(seen_start), 0);
    @(negedge clk); chk("R9", "seen_start after edge 4", int'(seen_start), 1);
    chk("R7", "irq after edge 4", int'(evt_irq), 1);
    chk("R9", "start gone after edge 4", int'(start_pulse), 0);

    // R4 reset in the middle of activity, after a stop
    sda = 1'b1;
    wait_neg(6);
    chk("R3", "stop before reset", int'(seen_stop), 1);
    rst_n = 1'b0;
    #1;
    chk("R4", "seen_stop after async reset", int'(seen_stop), 0);
    chk("R4", "seen_start after async reset", int'(seen_start), 0);
    chk("R8", "bus_idle after async reset", int'(bus_idle), 1);
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(8);
    chk("R4", "flags stay clear", int'(seen_start) + int'(seen_stop), 0);

    done = 1'b1;
    finish_run();
  end
endmodule